// File: doc/BRIEF.md
# Power-Managed Clock Mode Controller

This controller moves a small processor system between three clocking modes. In primary run, the system runs from the primary oscillator. In secondary idle, the processor clock is stopped and the peripherals run from the low-rate secondary oscillator, while the primary oscillator is powered down. In secondary run, the processor runs again from the secondary oscillator until the primary source is ready once more. Software selects the target mode by writing a two-bit clock-select field and holding an idle-enable level, then issuing a sleep command. A wake-up event starts the way back. The controller gives the processor a fixed settling delay, lets it run from the secondary clock, waits for the primary oscillator start-up count (plus a lock wait when the multiplied primary clock is chosen), and then switches back on its own.

The oscillators, the glitch-free clock multiplexer and the frequency multiplier are outside the block. They appear only as ready inputs, a source-select output and a power-down output. All counting runs on `clk`, a free-running clock of `CLK_KHZ` kHz. The wake delay and the lock wait are derived from that rate.

Top module: `pm_clk_ctrl`

## Requirements
- R1: After reset, cpu_clk_en=1, per_clk_en=1, clk_src_sel=0 (primary), pri_osc_off=0, pri_clk_stable=1, sec_clk_active=0, and mode_sel=2'b00.
- R2: A pulse on sel_wr loads sel_wdata into mode_sel one cycle later. If sel_wdata[0]=1 while sec_osc_en=0, bit 0 keeps its old value and bit 1 is still written.
- R3: A sleep command is accepted in primary run only when idle_en=1 and mode_sel=2'b01. Otherwise every output stays unchanged.
- R4: One cycle after an accepted sleep, cpu_clk_en and per_clk_en are both 0. They stay 0 for as long as sec_osc_rdy=0.
- R5: The first cycle after sec_osc_rdy is seen in that wait, the block enters secondary idle with per_clk_en=1, cpu_clk_en=0, clk_src_sel=1, pri_osc_off=1, pri_clk_stable=0 and sec_clk_active=1.
- R6: A wake event in secondary idle clears pri_osc_off one cycle later, with cpu_clk_en still 0. cpu_clk_en rises WAKE_CYC+1 cycles after that, with clk_src_sel still 1 (secondary run).
- R7: The primary source counts as ready after OST_CYC consecutive cycles with pri_osc_off=0 and pri_osc_rdy=1. When pll_sel=1, it additionally needs PLL_CYC further cycles. While pri_osc_rdy=0, secondary run is never left.
- R8: Once the primary source is ready in secondary run, the block spends exactly one cycle with both enables 0 and clk_src_sel unchanged. It then returns to primary run (R1 output values). clk_src_sel changes only after a cycle in which both enables were 0.
- R9: Wake events and sleep commands outside their accepting modes have no effect. A wake never changes mode_sel.
- R10: pri_clk_stable and sec_clk_active are always complementary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running counting clock (secondary-oscillator rate) |
| rst | input | 1 | Synchronous active-high reset |
| idle_en | input | 1 | Idle-enable level chosen by software |
| sel_wr | input | 1 | Write strobe for the clock-select field |
| sel_wdata | input | 2 | Clock-select write data |
| sec_osc_en | input | 1 | Secondary oscillator enabled; gates writes of select bit 0 |
| sleep_cmd | input | 1 | One-cycle sleep command |
| wake_evt | input | 1 | One-cycle wake-up event |
| pri_osc_rdy | input | 1 | Primary oscillator running |
| sec_osc_rdy | input | 1 | Secondary oscillator running |
| pll_sel | input | 1 | Primary path uses the frequency multiplier |
| mode_sel | output | 2 | Stored clock-select field |
| cpu_clk_en | output | 1 | Processor clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| clk_src_sel | output | 1 | Clock source select, 0 primary, 1 secondary |
| pri_osc_off | output | 1 | Primary oscillator power-down |
| pri_clk_stable | output | 1 | Status: system running from the primary source |
| sec_clk_active | output | 1 | Status: system running from the secondary source |

## Verification
All enables, the source select and both status flags come from one registered set that is decoded from the mode state. A wrong mode therefore shows as a wrong output pattern in the very next cycle. A miscounted delay shows up as an output change that comes one or more cycles early or late against the wake, start-up and lock counts. The bench measures those gaps exactly. A wrong select-field update shows up on mode_sel one cycle after the write.

// File: rtl/pm_clk_pkg.sv
package pm_clk_pkg;

  typedef enum logic [2:0] {
    ST_RUN_PRI  = 3'd0,
    ST_ENTER    = 3'd1,
    ST_IDLE_SEC = 3'd2,
    ST_WAKE_DLY = 3'd3,
    ST_RUN_SEC  = 3'd4,
    ST_SWAP     = 3'd5
  } pm_state_t;

  typedef struct packed {
    logic cpu_en;
    logic per_en;
    logic src_sec;
    logic pri_off;
    logic pri_stable;
    logic sec_active;
  } pm_outs_t;

  function automatic pm_outs_t outs_for(pm_state_t st);
    pm_outs_t o;
    case (st)
      ST_ENTER:    o = '{cpu_en:1'b0, per_en:1'b0, src_sec:1'b0, pri_off:1'b0, pri_stable:1'b1, sec_active:1'b0};
      ST_IDLE_SEC: o = '{cpu_en:1'b0, per_en:1'b1, src_sec:1'b1, pri_off:1'b1, pri_stable:1'b0, sec_active:1'b1};
      ST_WAKE_DLY: o = '{cpu_en:1'b0, per_en:1'b1, src_sec:1'b1, pri_off:1'b0, pri_stable:1'b0, sec_active:1'b1};
      ST_RUN_SEC:  o = '{cpu_en:1'b1, per_en:1'b1, src_sec:1'b1, pri_off:1'b0, pri_stable:1'b0, sec_active:1'b1};
      ST_SWAP:     o = '{cpu_en:1'b0, per_en:1'b0, src_sec:1'b1, pri_off:1'b0, pri_stable:1'b0, sec_active:1'b1};
      default:     o = '{cpu_en:1'b1, per_en:1'b1, src_sec:1'b0, pri_off:1'b0, pri_stable:1'b1, sec_active:1'b0};
    endcase
    return o;
  endfunction

endpackage

// File: rtl/pm_ready_timer.sv
module pm_ready_timer #(
  parameter int COUNT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic done
);
  localparam int W = $clog2(COUNT + 1);

  logic [W-1:0] cnt_q;

  assign done = (cnt_q == W'(COUNT));

  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= '0;
    else if (!done)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pm_sel_reg.sv
module pm_sel_reg (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr,
  input  logic [1:0] wdata,
  input  logic       sec_en,
  output logic [1:0] sel_q
);
  logic low_blocked;

  assign low_blocked = wdata[0] && !sec_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= 2'b00;
    end else if (wr) begin
      sel_q[1] <= wdata[1];
      if (!low_blocked) sel_q[0] <= wdata[0];
    end
  end
endmodule

// File: rtl/pm_mode_fsm.sv
module pm_mode_fsm
  import pm_clk_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       idle_en,
  input  logic [1:0] sel,
  input  logic       sleep_cmd,
  input  logic       wake_evt,
  input  logic       sec_rdy,
  input  logic       pri_ready,
  input  logic       wake_done,
  output pm_state_t  state_q,
  output pm_outs_t   outs_q
);
  pm_state_t state_d;
  logic      sleep_ok;

  assign sleep_ok = sleep_cmd && idle_en && (sel == 2'b01);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_RUN_PRI:  if (sleep_ok)  state_d = ST_ENTER;
      ST_ENTER:    if (sec_rdy)   state_d = ST_IDLE_SEC;
      ST_IDLE_SEC: if (wake_evt)  state_d = ST_WAKE_DLY;
      ST_WAKE_DLY: if (wake_done) state_d = ST_RUN_SEC;
      ST_RUN_SEC:  if (pri_ready) state_d = ST_SWAP;
      ST_SWAP:                    state_d = ST_RUN_PRI;
      default:                    state_d = ST_RUN_PRI;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_RUN_PRI;
      outs_q  <= outs_for(ST_RUN_PRI);
    end else begin
      state_q <= state_d;
      outs_q  <= outs_for(state_d);
    end
  end
endmodule

// File: rtl/pm_clk_ctrl.sv
module pm_clk_ctrl
  import pm_clk_pkg::*;
#(
  parameter int CLK_KHZ = 1000,
  parameter int WAKE_US = 10,
  parameter int PLL_US  = 2000,
  parameter int OST_CYC = 1024,
  parameter bit HAS_PLL = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       idle_en,
  input  logic       sel_wr,
  input  logic [1:0] sel_wdata,
  input  logic       sec_osc_en,
  input  logic       sleep_cmd,
  input  logic       wake_evt,
  input  logic       pri_osc_rdy,
  input  logic       sec_osc_rdy,
  input  logic       pll_sel,
  output logic [1:0] mode_sel,
  output logic       cpu_clk_en,
  output logic       per_clk_en,
  output logic       clk_src_sel,
  output logic       pri_osc_off,
  output logic       pri_clk_stable,
  output logic       sec_clk_active
);
  localparam int WAKE_RAW = (CLK_KHZ * WAKE_US + 999) / 1000;
  localparam int PLL_RAW  = (CLK_KHZ * PLL_US + 999) / 1000;
  localparam int WAKE_CYC = (WAKE_RAW < 1) ? 1 : WAKE_RAW;
  localparam int PLL_CYC  = (PLL_RAW < 1) ? 1 : PLL_RAW;

  pm_state_t state_q;
  pm_outs_t  outs_q;
  logic      ost_done, pll_done, wake_done, pri_ready;

  pm_sel_reg u_sel (
    .clk(clk), .rst(rst), .wr(sel_wr), .wdata(sel_wdata),
    .sec_en(sec_osc_en), .sel_q(mode_sel)
  );

  pm_ready_timer #(.COUNT(WAKE_CYC)) u_wake_tmr (
    .clk(clk), .rst(rst), .run(state_q == ST_WAKE_DLY), .done(wake_done)
  );

  pm_ready_timer #(.COUNT(OST_CYC)) u_ost_tmr (
    .clk(clk), .rst(rst), .run(!outs_q.pri_off && pri_osc_rdy), .done(ost_done)
  );

  generate
    if (HAS_PLL) begin : g_pll
      pm_ready_timer #(.COUNT(PLL_CYC)) u_pll_tmr (
        .clk(clk), .rst(rst), .run(ost_done && pll_sel), .done(pll_done)
      );
      assign pri_ready = ost_done && (!pll_sel || pll_done);
    end else begin : g_no_pll
      assign pll_done  = 1'b1;
      assign pri_ready = ost_done && pll_done;
    end
  endgenerate

  pm_mode_fsm u_fsm (
    .clk(clk), .rst(rst), .idle_en(idle_en), .sel(mode_sel),
    .sleep_cmd(sleep_cmd), .wake_evt(wake_evt), .sec_rdy(sec_osc_rdy),
    .pri_ready(pri_ready), .wake_done(wake_done),
    .state_q(state_q), .outs_q(outs_q)
  );

  assign cpu_clk_en     = outs_q.cpu_en;
  assign per_clk_en     = outs_q.per_en;
  assign clk_src_sel    = outs_q.src_sec;
  assign pri_osc_off    = outs_q.pri_off;
  assign pri_clk_stable = outs_q.pri_stable;
  assign sec_clk_active = outs_q.sec_active;
endmodule

// File: rtl/pm_clk_ctrl_chk.sv
module pm_clk_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       idle_en,
  input logic       sel_wr,
  input logic [1:0] sel_wdata,
  input logic       sec_osc_en,
  input logic       sleep_cmd,
  input logic       wake_evt,
  input logic       sec_osc_rdy,
  input logic [1:0] mode_sel,
  input logic       cpu_clk_en,
  input logic       per_clk_en,
  input logic       clk_src_sel,
  input logic       pri_osc_off,
  input logic       pri_clk_stable,
  input logic       sec_clk_active
);
  AST_SEL_LOW_GATED: assert property (@(posedge clk) disable iff (rst)
    (sel_wr && sel_wdata[0] && !sec_osc_en && !mode_sel[0]) |=> !mode_sel[0]); // R2

  AST_SLEEP_FILTER: assert property (@(posedge clk) disable iff (rst)
    (cpu_clk_en && !clk_src_sel && !(sleep_cmd && idle_en && mode_sel == 2'b01)) |=> cpu_clk_en); // R3

  AST_ENTRY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!cpu_clk_en && !per_clk_en && !clk_src_sel && !sec_osc_rdy) |=> !per_clk_en); // R4

  AST_SEC_SWITCH: assert property (@(posedge clk) disable iff (rst)
    $rose(clk_src_sel) |-> (pri_osc_off && sec_clk_active && $past(sec_osc_rdy))); // R5

  AST_WAKE_CPU_LATE: assert property (@(posedge clk) disable iff (rst)
    $fell(pri_osc_off) |-> !cpu_clk_en); // R6

  AST_SRC_GATED: assert property (@(posedge clk) disable iff (rst)
    (clk_src_sel != $past(clk_src_sel)) |-> (!$past(cpu_clk_en) && !$past(per_clk_en))); // R8

  AST_WAKE_KEEPS_SEL: assert property (@(posedge clk) disable iff (rst)
    (wake_evt && !sel_wr) |=> $stable(mode_sel)); // R9

  AST_STATUS_EXCL: assert property (@(posedge clk) disable iff (rst)
    (pri_clk_stable != sec_clk_active)); // R10
endmodule

bind pm_clk_ctrl pm_clk_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .idle_en(idle_en), .sel_wr(sel_wr), .sel_wdata(sel_wdata),
  .sec_osc_en(sec_osc_en), .sleep_cmd(sleep_cmd), .wake_evt(wake_evt),
  .sec_osc_rdy(sec_osc_rdy), .mode_sel(mode_sel), .cpu_clk_en(cpu_clk_en),
  .per_clk_en(per_clk_en), .clk_src_sel(clk_src_sel), .pri_osc_off(pri_osc_off),
  .pri_clk_stable(pri_clk_stable), .sec_clk_active(sec_clk_active)
);

// File: tb/pm_clk_ctrl_tb.sv
module pm_clk_ctrl_tb;
  localparam int WAKE_CYC = 10;
  localparam int OST_CYC  = 1024;
  localparam int PLL_CYC  = 2000;

  // output vector order: {cpu, per, src, off, pri_stable, sec_active}
  localparam logic [5:0] V_RUN_PRI = 6'b110010;
  localparam logic [5:0] V_ENTER   = 6'b000010;
  localparam logic [5:0] V_IDLE    = 6'b011101;
  localparam logic [5:0] V_WAKE    = 6'b011001;
  localparam logic [5:0] V_RUN_SEC = 6'b111001;
  localparam logic [5:0] V_SWAP    = 6'b001001;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic idle_en = 1'b0, sel_wr = 1'b0, sec_osc_en = 1'b0;
  logic [1:0] sel_wdata = 2'b00;
  logic sleep_cmd = 1'b0, wake_evt = 1'b0;
  logic pri_osc_rdy = 1'b1, sec_osc_rdy = 1'b0, pll_sel = 1'b0;
  logic [1:0] mode_sel;
  logic cpu_clk_en, per_clk_en, clk_src_sel, pri_osc_off, pri_clk_stable, sec_clk_active;

  int total = 0, bad = 0, cyc = 0, last_cyc = 0;
  bit mon_on = 1'b0, finished = 1'b0;
  logic [5:0] prev_v;
  logic [5:0] exp_q[$];
  int         gap_q[$];
  string      req_q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pm_clk_ctrl u_dut (
    .clk(clk), .rst(rst), .idle_en(idle_en), .sel_wr(sel_wr), .sel_wdata(sel_wdata),
    .sec_osc_en(sec_osc_en), .sleep_cmd(sleep_cmd), .wake_evt(wake_evt),
    .pri_osc_rdy(pri_osc_rdy), .sec_osc_rdy(sec_osc_rdy), .pll_sel(pll_sel),
    .mode_sel(mode_sel), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
    .clk_src_sel(clk_src_sel), .pri_osc_off(pri_osc_off),
    .pri_clk_stable(pri_clk_stable), .sec_clk_active(sec_clk_active)
  );

  function automatic logic [5:0] outv();
    return {cpu_clk_en, per_clk_en, clk_src_sel, pri_osc_off, pri_clk_stable, sec_clk_active};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic expect_chg(logic [5:0] v, int gap, string req);
    exp_q.push_back(v);
    gap_q.push_back(gap);
    req_q.push_back(req);
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic write_sel(logic [1:0] d);
    sel_wr = 1'b1; sel_wdata = d;
    tick(1);
    sel_wr = 1'b0;
    tick(1);
  endtask

  task automatic pulse_sleep();
    sleep_cmd = 1'b1; tick(1); sleep_cmd = 1'b0;
  endtask

  task automatic pulse_wake();
    wake_evt = 1'b1; tick(1); wake_evt = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (mon_on && outv() !== prev_v) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R3/R4/R9 unexpected change act=%b exp=%b", outv(), prev_v);
      end else begin
        logic [5:0] ev;
        int eg;
        string er;
        ev = exp_q.pop_front();
        eg = gap_q.pop_front();
        er = req_q.pop_front();
        check(er, 32'(outv()), 32'(ev));
        if (eg >= 0) check({er, " gap"}, 32'(cyc - last_cyc), 32'(eg));
      end
      last_cyc = cyc;
      prev_v = outv();
    end
  end

  task automatic finish_run();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      finish_run();
    end
  end

  initial begin
    tick(3);
    rst = 1'b0;
    @(negedge clk);
    check("R1 outputs", 32'(outv()), 32'(V_RUN_PRI));
    check("R1 mode_sel", 32'(mode_sel), 32'd0);
    prev_v = outv();
    mon_on = 1'b1;
    tick(1);

    // R2: low select bit blocked while secondary oscillator disabled
    write_sel(2'b01);
    check("R2 low bit blocked", 32'(mode_sel), 32'd0);
    write_sel(2'b11);
    check("R2 high bit written", 32'(mode_sel), 32'd2);
    write_sel(2'b00);
    sec_osc_en = 1'b1;
    write_sel(2'b10);
    check("R2 write 10", 32'(mode_sel), 32'd2);

    // R3: sleep ignored with wrong select, then without idle enable; R9 wake ignored
    idle_en = 1'b1;
    pulse_sleep(); tick(5);
    write_sel(2'b01);
    check("R2 low bit written when enabled", 32'(mode_sel), 32'd1);
    idle_en = 1'b0;
    pulse_sleep(); tick(5);
    pulse_wake(); tick(5);
    check("R3 still primary run", 32'(outv()), 32'(V_RUN_PRI));

    // Scenario A: no multiplier
    idle_en = 1'b1;
    expect_chg(V_ENTER, -1, "R4");
    pulse_sleep();
    tick(20);                                    // R4 hold while secondary not ready
    expect_chg(V_IDLE, -1, "R5");
    sec_osc_rdy = 1'b1;
    tick(5);
    pulse_sleep(); tick(3);                       // R9 sleep in idle ignored
    expect_chg(V_WAKE, -1, "R6");
    expect_chg(V_RUN_SEC, WAKE_CYC + 1, "R6");
    expect_chg(V_SWAP, OST_CYC - WAKE_CYC, "R7");
    expect_chg(V_RUN_PRI, 1, "R8");
    pulse_wake();
    tick(OST_CYC + 50);
    check("R9 mode_sel after wake", 32'(mode_sel), 32'd1);
    check("R8 back to primary", 32'(outv()), 32'(V_RUN_PRI));

    // Scenario B: multiplier lock wait
    pll_sel = 1'b1;
    expect_chg(V_ENTER, -1, "R4");
    expect_chg(V_IDLE, 1, "R5");
    pulse_sleep();
    tick(5);
    expect_chg(V_WAKE, -1, "R6");
    expect_chg(V_RUN_SEC, WAKE_CYC + 1, "R6");
    expect_chg(V_SWAP, OST_CYC + PLL_CYC - WAKE_CYC, "R7");
    expect_chg(V_RUN_PRI, 1, "R8");
    pulse_wake();
    tick(OST_CYC + PLL_CYC + 50);

    // Scenario C: primary oscillator not running holds secondary run
    pll_sel = 1'b0;
    pri_osc_rdy = 1'b0;
    expect_chg(V_ENTER, -1, "R4");
    expect_chg(V_IDLE, 1, "R5");
    pulse_sleep();
    tick(5);
    expect_chg(V_WAKE, -1, "R6");
    expect_chg(V_RUN_SEC, WAKE_CYC + 1, "R6");
    pulse_wake();
    tick(2000);
    check("R7 held in secondary run", 32'(outv()), 32'(V_RUN_SEC));
    expect_chg(V_SWAP, -1, "R7");
    expect_chg(V_RUN_PRI, 1, "R8");
    pri_osc_rdy = 1'b1;
    tick(OST_CYC + 50);
    check("R9 mode_sel final", 32'(mode_sel), 32'd1);
    check("R8 all expected changes seen", 32'(exp_q.size()), 32'd0);
    finish_run();
  end
endmodule